// File: doc/BRIEF.md
# Ten-Channel DMA Arbiter and Bus Sequencer

This block sits between ten DMA channels and an internal bus that the DMA shares with a CPU. Each channel has an enable bit and a select field. The select field picks one of several candidate request lines wired to that channel. A rising edge on the selected line marks the channel as pending. The channel only marks itself pending while it is enabled, and a line that was already high when the channel was enabled does not count.

Whenever the sequencer is idle, a fixed-priority picker chooses the lowest-numbered pending channel. The sequencer then raises a bus request and waits as long as needed for the grant. It runs one read cycle and one write cycle, then releases the bus with a one-cycle completion pulse that carries the serviced channel number. Priority is decided again before every single transfer. The bus returns to the CPU after every transfer, so no channel keeps the bus for a burst. Addresses, data, counts and interrupts belong to neighbouring logic, which uses the strobes and the channel index.

Top module: `dma_ten_ch_arb`

## Requirements
- R1: When several channels are pending, they are serviced in ascending channel order. Channel 0 always wins, and no input changes this order.
- R2: The winner is chosen again before each transfer. A higher-priority channel that becomes pending while another transfer is under way is serviced next, ahead of lower-priority channels that were pending earlier.
- R3: A rising edge on a channel whose enable bit is 0 is ignored. Clearing an enable bit drops that channel's pending request. A transfer that has already started for that channel still runs to completion.
- R4: The select value k of channel c (bits c*SEL_W upward of the select bus) makes only request line c*NUM_SRC+k count for that channel. Only a 0-to-1 change of that line starts a transfer. A line that is already high when the channel is enabled starts nothing.
- R5: A rising edge at clock edge n marks the channel pending at edge n. With the sequencer idle, bus_req is high after edge n+1, and active_ch then shows the chosen channel. bus_req stays high with no strobe for as long as bus_grant is low. rd_strobe is high in the cycle after the first cycle in which bus_grant is seen high.
- R6: Each transfer has exactly one read cycle and one write cycle, each one clock long, with the write directly after the read. A completion cycle follows, so the bus cycle spans three clocks.
- R7: bus_req stays high until the write cycle ends. It is low in the completion cycle and in at least one further cycle before the next request.
- R8: done_pulse is high for exactly one cycle, directly after the write cycle. In that cycle done_ch holds the serviced channel.
- R9: If the serviced channel sees a new rising edge in the same cycle that its completion clears its pending request, the new request is kept, and the channel is serviced again.
- R10: After reset, bus_req, rd_strobe, wr_strobe and done_pulse are all 0, and no channel is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ch_enable | input | NUM_CH | Per-channel enable |
| ch_cause_sel | input | NUM_CH*SEL_W | Per-channel request-line select, channel c at bits c*SEL_W upward |
| ch_cause_in | input | NUM_CH*NUM_SRC | Candidate request lines, line k of channel c at bit c*NUM_SRC+k |
| bus_grant | input | 1 | CPU grants the internal bus |
| bus_req | output | 1 | DMA asks for the internal bus |
| rd_strobe | output | 1 | Read cycle of the transfer |
| wr_strobe | output | 1 | Write cycle of the transfer |
| active_ch | output | IDX_W | Channel owning the current transfer |
| done_pulse | output | 1 | One-cycle transfer completion |
| done_ch | output | IDX_W | Channel whose transfer just completed |

## Verification
Two things can happen in one cycle. A channel's completion clears its pending flag, and a fresh rising edge can arrive on the same channel's request line. The bench waits for the completion pulse of a channel and raises that channel's request line in the same cycle, so the new edge reaches the latch on the clock edge that applies the clear. It then judges the result by whether a second transfer for that channel follows. A second case is arbitration during a transfer. The bench holds the grant low while requests for higher- and lower-priority channels arrive, and checks the order of the completion pulses.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_ASK,
    SEQ_READ,
    SEQ_WRITE,
    SEQ_FINISH
  } seq_state_e;

endpackage

// File: rtl/dma_req_latch.sv
module dma_req_latch #(
  parameter int NUM_SRC = 4,
  localparam int SEL_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_SRC-1:0] src,
  input  logic               clr,
  output logic               pending
);

  logic cause_now;
  logic cause_prev_q;
  logic pend_q;
  logic pend_d;
  logic rise;

  always_comb begin
    cause_now = src[sel];
    rise      = cause_now & ~cause_prev_q;
  end

  // A new edge takes precedence over the completion clear.
  always_comb begin
    if (!enable)    pend_d = 1'b0;
    else if (rise)  pend_d = 1'b1;
    else if (clr)   pend_d = 1'b0;
    else            pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_prev_q <= 1'b0;
      pend_q       <= 1'b0;
    end else begin
      cause_prev_q <= cause_now;
      pend_q       <= pend_d;
    end
  end

  assign pending = pend_q;

  // R3: a disabled channel holds no pending request in the next cycle
  a_r3_off_drops_pending: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pend_q);

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NUM_CH = 10,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req,
  output logic              any,
  output logic [IDX_W-1:0]  idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 10,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_pend,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic              bus_grant,
  output logic              bus_req,
  output logic              rd_strobe,
  output logic              wr_strobe,
  output logic              done_pulse,
  output logic [IDX_W-1:0]  cur_ch,
  output logic [NUM_CH-1:0] clr_vec
);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] ch_q;
  logic             ch_load;

  always_comb begin
    state_d = state_q;
    ch_load = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (any_pend) begin
          state_d = SEQ_ASK;
          ch_load = 1'b1;
        end
      end
      SEQ_ASK:    if (bus_grant) state_d = SEQ_READ;
      SEQ_READ:   state_d = SEQ_WRITE;
      SEQ_WRITE:  state_d = SEQ_FINISH;
      SEQ_FINISH: state_d = SEQ_IDLE;
      default:    state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      ch_q    <= '0;
    end else begin
      state_q <= state_d;
      if (ch_load) ch_q <= win_idx;
    end
  end

  always_comb begin
    bus_req    = (state_q == SEQ_ASK) || (state_q == SEQ_READ) || (state_q == SEQ_WRITE);
    rd_strobe  = (state_q == SEQ_READ);
    wr_strobe  = (state_q == SEQ_WRITE);
    done_pulse = (state_q == SEQ_FINISH);
    cur_ch     = ch_q;
    clr_vec    = '0;
    if (done_pulse) clr_vec[ch_q] = 1'b1;
  end

  // R5: a read only follows a cycle with both request and grant high
  a_r5_read_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_strobe) |-> ($past(bus_grant) && $past(bus_req)));

  // R6: one read clock, then exactly the write
  a_r6_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> (wr_strobe && !rd_strobe));

  // R7: once the request drops it stays low one more cycle
  a_r7_request_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |=> !bus_req);

  // R8: completion directly after the write, single cycle
  a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> ($past(wr_strobe) && !bus_req));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

endmodule

// File: rtl/dma_ten_ch_arb.sv
module dma_ten_ch_arb #(
  parameter int NUM_CH  = 10,
  parameter int NUM_SRC = 4,
  localparam int IDX_W  = $clog2(NUM_CH),
  localparam int SEL_W  = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         ch_enable,
  input  logic [NUM_CH*SEL_W-1:0]   ch_cause_sel,
  input  logic [NUM_CH*NUM_SRC-1:0] ch_cause_in,
  input  logic                      bus_grant,
  output logic                      bus_req,
  output logic                      rd_strobe,
  output logic                      wr_strobe,
  output logic [IDX_W-1:0]          active_ch,
  output logic                      done_pulse,
  output logic [IDX_W-1:0]          done_ch
);

  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NUM_CH-1:0] pend_vec;
  logic [NUM_CH-1:0] clr_vec;
  logic              any_pend;
  logic [IDX_W-1:0]  win_idx;
  logic [IDX_W-1:0]  cur_ch;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    dma_req_latch #(.NUM_SRC(NUM_SRC)) i_latch (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .enable  (ch_enable[c]),
      .sel     (ch_cause_sel[c*SEL_W +: SEL_W]),
      .src     (ch_cause_in[c*NUM_SRC +: NUM_SRC]),
      .clr     (clr_vec[c]),
      .pending (pend_vec[c])
    );
  end

  dma_prio_pick #(.NUM_CH(NUM_CH)) i_pick (
    .req (pend_vec),
    .any (any_pend),
    .idx (win_idx)
  );

  dma_bus_seq #(.NUM_CH(NUM_CH)) i_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .any_pend   (any_pend),
    .win_idx    (win_idx),
    .bus_grant  (bus_grant),
    .bus_req    (bus_req),
    .rd_strobe  (rd_strobe),
    .wr_strobe  (wr_strobe),
    .done_pulse (done_pulse),
    .cur_ch     (cur_ch),
    .clr_vec    (clr_vec)
  );

  assign active_ch = cur_ch;
  assign done_ch   = cur_ch;

  logic [NUM_CH-1:0] lower_mask;
  always_comb lower_mask = (NUM_CH'(1) << cur_ch) - NUM_CH'(1);

  // R1: a new request never skips a pending lower-numbered channel
  a_r1_lowest_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(bus_req) |-> (($past(pend_vec) & lower_mask) == '0));

  // R10: nothing pending right after reset release
  a_r10_clean_start: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> (pend_vec == '0));

endmodule

// File: tb/test_dma_ten_ch_arb.sv
module test_dma_ten_ch_arb;

  localparam int NUM_CH  = 10;
  localparam int NUM_SRC = 4;
  localparam int IDX_W   = 4;
  localparam int SEL_W   = 2;
  localparam int NVEC    = 6;
  localparam logic [NUM_CH-1:0] VEC [NVEC] = '{
    10'h001, 10'h200, 10'h3FF, 10'h0A4, 10'h111, 10'h30C
  };

  logic                      clk = 1'b0;
  logic                      rst_n = 1'b0;
  logic [NUM_CH-1:0]         ch_enable = '1;
  logic [NUM_CH*SEL_W-1:0]   ch_cause_sel = '0;
  logic [NUM_CH*NUM_SRC-1:0] ch_cause_in = '0;
  logic                      bus_grant = 1'b1;
  logic                      bus_req, rd_strobe, wr_strobe, done_pulse;
  logic [IDX_W-1:0]          active_ch, done_ch;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dma_ten_ch_arb i_dma_ten_ch_arb (
    .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .ch_cause_sel(ch_cause_sel),
    .ch_cause_in(ch_cause_in), .bus_grant(bus_grant), .bus_req(bus_req),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .active_ch(active_ch),
    .done_pulse(done_pulse), .done_ch(done_ch)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_src(input int ch, input int src);
    ch_cause_in[ch*NUM_SRC + src] = 1'b1;
    tick(1);
    ch_cause_in[ch*NUM_SRC + src] = 1'b0;
  endtask

  task automatic wait_done(output int ch);
    ch = -1;
    for (int i = 0; i < 80; i++) begin
      tick(1);
      if (done_pulse) begin
        ch = int'(done_ch);
        return;
      end
    end
  endtask

  task automatic expect_quiet(input int n, input string req);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (bus_req) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int got;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    // R10 reset state
    check(!bus_req && !rd_strobe && !wr_strobe && !done_pulse, "R10 outputs idle",
          int'({bus_req, rd_strobe, wr_strobe, done_pulse}), 0);
    expect_quiet(5, "R10 nothing pending");

    // Vector table: pulse all masked channels together, expect ascending service
    for (int v = 0; v < NVEC; v++) begin
      ch_cause_in = '0;
      for (int c = 0; c < NUM_CH; c++) if (VEC[v][c]) ch_cause_in[c*NUM_SRC] = 1'b1;
      tick(1);
      ch_cause_in = '0;
      for (int c = 0; c < NUM_CH; c++) begin
        if (VEC[v][c]) begin
          wait_done(got);
          check(got == c, "R1 ascending order", got, c);
          tick(1);
          check(!bus_req, "R7 gap after transfer", int'(bus_req), 0);
        end
      end
      expect_quiet(12, "R1 no extra transfer");
    end

    // R5/R6/R7/R8 cycle timing with grant high
    ch_cause_in[0] = 1'b1;
    tick(1);
    ch_cause_in[0] = 1'b0;
    check(!bus_req, "R5 no request at pending edge", int'(bus_req), 0);
    tick(1);
    check(bus_req && !rd_strobe && active_ch == 0, "R5 request next edge",
          int'({bus_req, rd_strobe}), 2);
    tick(1);
    check(rd_strobe && bus_req && !wr_strobe, "R6 read cycle", int'({rd_strobe, wr_strobe}), 2);
    tick(1);
    check(wr_strobe && bus_req && !rd_strobe, "R6 write cycle", int'({rd_strobe, wr_strobe}), 1);
    tick(1);
    check(done_pulse && !bus_req && !wr_strobe && done_ch == 0, "R8 completion",
          int'({done_pulse, bus_req}), 2);
    tick(1);
    check(!done_pulse && !bus_req, "R7 R8 after completion", int'({done_pulse, bus_req}), 0);

    // R5 grant wait
    bus_grant = 1'b0;
    pulse_src(7, 0);
    tick(10);
    check(bus_req && !rd_strobe && active_ch == 7, "R5 waits for grant",
          int'(active_ch), 7);
    bus_grant = 1'b1;
    tick(1);
    check(rd_strobe, "R5 read after grant", int'(rd_strobe), 1);
    wait_done(got);
    check(got == 7, "R5 grant transfer done", got, 7);

    // R2 re-arbitration while a transfer waits
    bus_grant = 1'b0;
    pulse_src(5, 0);
    tick(3);
    pulse_src(9, 0);
    pulse_src(1, 0);
    tick(2);
    bus_grant = 1'b1;
    wait_done(got);
    check(got == 5, "R2 current transfer first", got, 5);
    wait_done(got);
    check(got == 1, "R2 higher priority next", got, 1);
    wait_done(got);
    check(got == 9, "R2 lowest last", got, 9);
    expect_quiet(10, "R2 queue empty");

    // R3 disable during wait: started transfer completes, pending one dropped
    bus_grant = 1'b0;
    ch_cause_in[6*NUM_SRC] = 1'b1;
    ch_cause_in[8*NUM_SRC] = 1'b1;
    tick(1);
    ch_cause_in = '0;
    tick(3);
    check(bus_req && active_ch == 6, "R3 ch6 owns request", int'(active_ch), 6);
    ch_enable[6] = 1'b0;
    ch_enable[8] = 1'b0;
    tick(3);
    bus_grant = 1'b1;
    wait_done(got);
    check(got == 6, "R3 started transfer completes", got, 6);
    expect_quiet(20, "R3 disabled pending dropped");
    ch_enable[6] = 1'b1;
    ch_enable[8] = 1'b1;

    // R3 edge on disabled channel ignored
    ch_enable[4] = 1'b0;
    pulse_src(4, 0);
    tick(2);
    ch_enable[4] = 1'b1;
    expect_quiet(20, "R3 disabled edge ignored");

    // R4 cause high before enable: no transfer; fresh edge: transfer
    ch_enable[3] = 1'b0;
    ch_cause_in[3*NUM_SRC] = 1'b1;
    tick(2);
    ch_enable[3] = 1'b1;
    expect_quiet(20, "R4 level at enable ignored");
    ch_cause_in[3*NUM_SRC] = 1'b0;
    tick(2);
    pulse_src(3, 0);
    wait_done(got);
    check(got == 3, "R4 fresh edge serviced", got, 3);

    // R4 select field picks the line
    ch_cause_sel[2*SEL_W +: SEL_W] = 2'd2;
    tick(1);
    pulse_src(2, 1);
    expect_quiet(15, "R4 unselected line ignored");
    pulse_src(2, 2);
    wait_done(got);
    check(got == 2, "R4 selected line serviced", got, 2);
    ch_cause_sel = '0;
    tick(3);

    // R9 new edge coinciding with the completion clear
    pulse_src(1, 0);
    wait_done(got);
    check(got == 1, "R9 first transfer", got, 1);
    ch_cause_in[1*NUM_SRC] = 1'b1;
    tick(1);
    ch_cause_in[1*NUM_SRC] = 1'b0;
    wait_done(got);
    check(got == 1, "R9 coinciding edge kept", got, 1);
    expect_quiet(12, "R9 no third transfer");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule